// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer with Link Register and Loop Counter

This block decides which control-store word a microprogrammed controller fetches next. On every enabled step it reads the sequencing fields of the microinstruction now at the current microaddress. These fields are supplied already decoded. From them it forms the following address: the next sequential word, a literal branch target (optionally gated by a condition input), a target with a link register ORed into it, or the link register itself.

Arithmetic/logic microinstructions can carry a jump modifier, a decrement modifier, or both. With both set they form a counted loop over an 8-bit counter that closes back to the link address. A branch can also run in one-shot mode: the single word at the target executes, then control returns to the word after the branch. The link register and the loop counter are written through their own synchronous load ports. The control store, the datapath and the instruction decoder sit outside this block.

Top module: `useq_next_addr`

## Requirements
- R1: During asynchronous reset (rst_n low) uaddr, the link register, the loop counter and the one-shot state all become zero, so the first enabled jump through the link register goes to address 0.
- R2: When step_en is high, no one-shot return is pending, and the step is not a taken branch or a link jump, uaddr becomes uaddr+1 (modulo 2^AW). This covers seq_kind 0 (plain step) and 3 (treated as a plain step).
- R3: With seq_kind 1 (branch), the branch is taken when br_cond is 0, or when br_cond is 1 and test_in is 1; a taken branch loads br_addr into uaddr. A branch that is not taken acts as a plain step and does not arm the one-shot mode.
- R4: A taken branch with br_or_link set goes to br_addr bitwise-ORed with the current link register value.
- R5: With seq_kind 2 (arithmetic/logic), op_jump set and op_dec clear, uaddr becomes the current link register value.
- R6: With seq_kind 2 and both op_jump and op_dec set, the loop counter is decremented. If the decremented value is nonzero, uaddr becomes the link value; if it is zero, uaddr becomes uaddr+1. A counter at 0 wraps to 255 and therefore jumps.
- R7: A taken branch with br_once set goes to its target. On the next enabled step, uaddr becomes the branch address plus one, whatever the sequencing fields of that target word hold. The target word also performs no counter decrement.
- R8: br_or_link and br_once may be set together: the one-shot target is br_addr ORed with the link value, and the return is still to the branch address plus one.
- R9: link_wr and loop_wr load their registers at the next clock edge whatever the value of step_en. A counter load in the same cycle as a decrement wins over the decrement. The loop decision in that cycle still uses the decremented old count.
- R10: While step_en is low, uaddr, the one-shot state and the loop counter (unless loaded) keep their values.
- R11: With seq_kind 2, op_dec set and op_jump clear, the counter is decremented and uaddr becomes uaddr+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Advance the sequencer this cycle |
| seq_kind | input | 2 | 0 step, 1 branch, 2 arithmetic/logic, 3 step |
| br_addr | input | AW (16) | Literal branch target |
| br_cond | input | 1 | Branch is conditional on test_in |
| br_or_link | input | 1 | OR the link register into the target |
| br_once | input | 1 | Execute only the target word, then return |
| op_jump | input | 1 | Jump-through-link modifier |
| op_dec | input | 1 | Decrement-loop-counter modifier |
| test_in | input | 1 | Selected condition result |
| link_wr | input | 1 | Load the link register |
| link_wdata | input | AW (16) | Link register load value |
| loop_wr | input | 1 | Load the loop counter |
| loop_wdata | input | CW (8) | Loop counter load value |
| uaddr | output | AW (16) | Current microaddress |

## Verification
Each sequencing decision made while step_en is high shows up on uaddr one clock edge later. A register load shows up only in the decision of the next step, and the one-shot return shows up two enabled edges after the branch. The bench drives every step shortly after a rising edge and samples uaddr one nanosecond after the following edge. It compares the sample against a behavioural model advanced once per edge, and against a hand-computed address for the named cases. Loads, decrements and holds are observed only through the addresses they produce later: loop exit points, link jumps and one-shot returns.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    SK_STEP   = 2'd0,
    SK_BRANCH = 2'd1,
    SK_ALU    = 2'd2,
    SK_SPARE  = 2'd3
  } seq_kind_e;
endpackage

// File: rtl/useq_link_regs.sv
module useq_link_regs #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_go,
  input  logic          link_wr,
  input  logic [AW-1:0] link_wdata,
  input  logic          loop_wr,
  input  logic [CW-1:0] loop_wdata,
  output logic [AW-1:0] link_q,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_dec
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_dec = cnt_q - CW'(1);

  always_comb begin
    cnt_en = loop_wr | dec_go;
    cnt_d  = loop_wr ? loop_wdata : cnt_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (link_wr) link_q <= link_wdata;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/useq_xq_ctl.sv
module useq_xq_ctl #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic          issue,
  input  logic [AW-1:0] ret_in,
  output logic          pend_q,
  output logic [AW-1:0] ret_q
);
  logic          pend_d;
  logic [AW-1:0] ret_d;

  always_comb begin
    pend_d = pend_q;
    ret_d  = ret_q;
    if (pend_q) begin
      pend_d = 1'b0;
    end else if (issue) begin
      pend_d = 1'b1;
      ret_d  = ret_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      ret_q  <= '0;
    end else if (step_en) begin
      pend_q <= pend_d;
      ret_q  <= ret_d;
    end
  end
endmodule

// File: rtl/useq_addr_mux.sv
module useq_addr_mux
  import useq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic [AW-1:0] uaddr,
  input  logic [1:0]    seq_kind,
  input  logic [AW-1:0] br_addr,
  input  logic          br_cond,
  input  logic          br_or_link,
  input  logic          br_once,
  input  logic          op_jump,
  input  logic          op_dec,
  input  logic          test_in,
  input  logic [AW-1:0] link_q,
  input  logic [CW-1:0] cnt_dec,
  input  logic          pend_q,
  input  logic [AW-1:0] ret_q,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] next_addr,
  output logic          xq_issue,
  output logic          dec_req
);
  logic          br_taken;
  logic          loop_more;
  logic [AW-1:0] br_tgt;

  assign seq_addr  = uaddr + AW'(1);
  assign br_taken  = ~br_cond | test_in;
  assign loop_more = (cnt_dec != '0);
  assign br_tgt    = br_addr | (br_or_link ? link_q : '0);

  always_comb begin
    next_addr = seq_addr;
    xq_issue  = 1'b0;
    dec_req   = 1'b0;
    if (pend_q) begin
      next_addr = ret_q;
    end else begin
      case (seq_kind_e'(seq_kind))
        SK_BRANCH: begin
          if (br_taken) begin
            next_addr = br_tgt;
            xq_issue  = br_once;
          end
        end
        SK_ALU: begin
          dec_req = op_dec;
          if (op_jump && (!op_dec || loop_more)) next_addr = link_q;
        end
        default: next_addr = seq_addr;
      endcase
    end
  end
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [1:0]    seq_kind,
  input  logic [AW-1:0] br_addr,
  input  logic          br_cond,
  input  logic          br_or_link,
  input  logic          br_once,
  input  logic          op_jump,
  input  logic          op_dec,
  input  logic          test_in,
  input  logic          link_wr,
  input  logic [AW-1:0] link_wdata,
  input  logic          loop_wr,
  input  logic [CW-1:0] loop_wdata,
  output logic [AW-1:0] uaddr
);
  logic [AW-1:0] link_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;
  logic          pend_q;
  logic [AW-1:0] ret_q;
  logic [AW-1:0] seq_addr;
  logic [AW-1:0] next_addr;
  logic          xq_issue;
  logic          dec_req;
  logic [AW-1:0] uaddr_d;

  useq_link_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .dec_go(step_en & dec_req),
    .link_wr(link_wr), .link_wdata(link_wdata),
    .loop_wr(loop_wr), .loop_wdata(loop_wdata),
    .link_q(link_q), .cnt_q(cnt_q), .cnt_dec(cnt_dec)
  );

  useq_xq_ctl #(.AW(AW)) u_xq (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .issue(xq_issue),
    .ret_in(seq_addr), .pend_q(pend_q), .ret_q(ret_q)
  );

  useq_addr_mux #(.AW(AW), .CW(CW)) u_mux (
    .uaddr(uaddr), .seq_kind(seq_kind), .br_addr(br_addr),
    .br_cond(br_cond), .br_or_link(br_or_link), .br_once(br_once),
    .op_jump(op_jump), .op_dec(op_dec), .test_in(test_in),
    .link_q(link_q), .cnt_dec(cnt_dec), .pend_q(pend_q), .ret_q(ret_q),
    .seq_addr(seq_addr), .next_addr(next_addr),
    .xq_issue(xq_issue), .dec_req(dec_req)
  );

  always_comb uaddr_d = step_en ? next_addr : uaddr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) uaddr <= '0;
    else        uaddr <= uaddr_d;
  end
endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_en,
  input logic [1:0]    seq_kind,
  input logic          op_jump,
  input logic          op_dec,
  input logic          loop_wr,
  input logic [CW-1:0] loop_wdata,
  input logic [AW-1:0] uaddr,
  input logic [AW-1:0] link_q,
  input logic [CW-1:0] cnt_q,
  input logic          pend_q,
  input logic [AW-1:0] ret_q
);
  AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !pend_q && (seq_kind == 2'd0 || seq_kind == 2'd3)) |=> (uaddr == $past(uaddr) + AW'(1))); // R2

  AST_LINK_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !pend_q && seq_kind == 2'd2 && op_jump && !op_dec) |=> (uaddr == $past(link_q))); // R5

  AST_ONCE_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && pend_q) |=> (uaddr == $past(ret_q) && !pend_q)); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(uaddr) && $stable(pend_q))); // R10

  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !loop_wr) |=> $stable(cnt_q)); // R10

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    loop_wr |=> (cnt_q == $past(loop_wdata))); // R9
endmodule

bind useq_next_addr useq_next_addr_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_en(step_en), .seq_kind(seq_kind),
  .op_jump(op_jump), .op_dec(op_dec), .loop_wr(loop_wr),
  .loop_wdata(loop_wdata), .uaddr(uaddr), .link_q(link_q),
  .cnt_q(cnt_q), .pend_q(pend_q), .ret_q(ret_q)
);

// File: tb/useq_next_addr_bench.sv
`timescale 1ns/1ps
module useq_next_addr_bench;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam int AM = (1 << AW) - 1;
  localparam int CM = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_en = 1'b0;
  logic [1:0]    seq_kind = 2'd0;
  logic [AW-1:0] br_addr = '0;
  logic          br_cond = 1'b0, br_or_link = 1'b0, br_once = 1'b0;
  logic          op_jump = 1'b0, op_dec = 1'b0, test_in = 1'b0;
  logic          link_wr = 1'b0, loop_wr = 1'b0;
  logic [AW-1:0] link_wdata = '0;
  logic [CW-1:0] loop_wdata = '0;
  logic [AW-1:0] uaddr;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int m_addr = 0, m_link = 0, m_cnt = 0, m_ret = 0;
  bit m_pend = 0;

  always #2 clk = ~clk;

  useq_next_addr #(.AW(AW), .CW(CW)) u_useq_next_addr (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .seq_kind(seq_kind),
    .br_addr(br_addr), .br_cond(br_cond), .br_or_link(br_or_link),
    .br_once(br_once), .op_jump(op_jump), .op_dec(op_dec), .test_in(test_in),
    .link_wr(link_wr), .link_wdata(link_wdata), .loop_wr(loop_wr),
    .loop_wdata(loop_wdata), .uaddr(uaddr)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s uaddr actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    step_en = 1'b1; seq_kind = 2'd0; br_addr = '0; br_cond = 0; br_or_link = 0;
    br_once = 0; op_jump = 0; op_dec = 0; test_in = 0;
    link_wr = 0; loop_wr = 0; link_wdata = '0; loop_wdata = '0;
  endtask

  // advance model one edge with current inputs, then compare after the edge
  task automatic tick(input string req, input int exp);
    int nxt, cd, na, nc, nr;
    bit dec_now, np;
    nxt = (m_addr + 1) & AM; dec_now = 0; np = m_pend; nr = m_ret;
    cd = (m_cnt - 1) & CM;
    if (step_en) begin
      if (m_pend) begin
        nxt = m_ret; np = 0;
      end else if (seq_kind == 2'd1) begin
        if (!br_cond || test_in) begin
          nxt = br_or_link ? (int'(br_addr) | m_link) : int'(br_addr);
          if (br_once) begin np = 1; nr = (m_addr + 1) & AM; end
        end
      end else if (seq_kind == 2'd2) begin
        dec_now = op_dec;
        if (op_jump && (!op_dec || cd != 0)) nxt = m_link;
      end
      na = nxt;
    end else na = m_addr;
    nc = loop_wr ? int'(loop_wdata) : (dec_now ? cd : m_cnt);
    if (link_wr) m_link = int'(link_wdata);
    m_cnt = nc; m_addr = na; m_pend = np; m_ret = nr;
    @(posedge clk); #1;
    check("model", int'(uaddr), m_addr);
    if (exp >= 0) check(req, int'(uaddr), exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clr(); step_en = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", int'(uaddr), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 hold", int'(uaddr), 0);
    // R1: link cleared, jump goes to 0
    clr(); seq_kind = 2'd2; op_jump = 1; tick("R1 link zero", 0);
    clr(); tick("R2 step", 1);
    clr(); tick("R2 step", 2);
    clr(); seq_kind = 2'd3; tick("R2 spare kind", 3);
    clr(); seq_kind = 2'd2; tick("R2 alu no mod", 4);
    clr(); link_wr = 1; link_wdata = 16'h0100; tick("R2 step with load", 5);
    clr(); seq_kind = 2'd1; br_addr = 16'h0040; tick("R3 uncond", 16'h0040);
    clr(); seq_kind = 2'd1; br_addr = 16'h0900; br_cond = 1; test_in = 0; br_once = 1;
    tick("R3 not taken", 16'h0041);
    clr(); tick("R3 no once armed", 16'h0042);
    clr(); seq_kind = 2'd1; br_addr = 16'h0200; br_cond = 1; test_in = 1;
    tick("R3 cond taken", 16'h0200);
    clr(); seq_kind = 2'd1; br_addr = 16'h0023; br_or_link = 1;
    tick("R4 or link", 16'h0123);
    clr(); seq_kind = 2'd2; op_jump = 1; tick("R5 link jump", 16'h0100);
    // R6 loop of three passes
    clr(); loop_wr = 1; loop_wdata = 8'd3; tick("R6 setup", 16'h0101);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R6 loop back", 16'h0100);
    clr(); tick("R6 body", 16'h0101);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R6 loop back", 16'h0100);
    clr(); tick("R6 body", 16'h0101);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R6 exit", 16'h0102);
    clr(); seq_kind = 2'd2; op_dec = 1; tick("R11 dec only", 16'h0103);
    // R10 idle: no move, no decrement
    clr(); loop_wr = 1; loop_wdata = 8'd1; tick("R10 setup", 16'h0104);
    clr(); step_en = 0; seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R10 hold", 16'h0104);
    clr(); step_en = 0; seq_kind = 2'd1; br_addr = 16'h0777; tick("R10 hold br", 16'h0104);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R10 count kept", 16'h0105);
    // R9 load beats decrement; decision uses old count (0 -> 255)
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; loop_wr = 1; loop_wdata = 8'd2;
    tick("R9 wrap jump", 16'h0100);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R9 loaded 2", 16'h0100);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R9 exit", 16'h0101);
    // R7 one-shot
    clr(); seq_kind = 2'd1; br_addr = 16'h0300; br_once = 1; tick("R7 to target", 16'h0300);
    clr(); seq_kind = 2'd1; br_addr = 16'h0555; tick("R7 return", 16'h0102);
    clr(); tick("R7 after", 16'h0103);
    clr(); seq_kind = 2'd1; br_addr = 16'h0310; br_once = 1; tick("R7 target2", 16'h0310);
    clr(); seq_kind = 2'd2; op_jump = 1; op_dec = 1; tick("R7 target no dec", 16'h0104);
    clr(); seq_kind = 2'd2; op_dec = 1; op_jump = 1; loop_wr = 0; tick("R7 count unchanged", 16'h0100);
    // R8 index with one-shot
    clr(); seq_kind = 2'd1; br_addr = 16'h0034; br_or_link = 1; br_once = 1;
    tick("R8 target", 16'h0134);
    clr(); step_en = 0; tick("R8 idle in target", 16'h0134);
    clr(); tick("R8 return", 16'h0101);
    // R9 link load while idle
    clr(); step_en = 0; link_wr = 1; link_wdata = 16'h0AA0; tick("R9 idle load", 16'h0101);
    clr(); seq_kind = 2'd2; op_jump = 1; tick("R9 new link", 16'h0AA0);
    // R2 wrap
    clr(); seq_kind = 2'd1; br_addr = 16'hFFFF; tick("R2 top", 16'hFFFF);
    clr(); tick("R2 wrap", 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule